// File: doc/BRIEF.md
# Wake-capable GPIO Port

This block controls a bank of up to eight general-purpose pins through a four-register bus. A data latch supplies the level driven on pins that are outputs. A direction register makes each pin an output or an input. A pull-up select register turns on a weak pull-up for input pins. A wake select register chooses which pins can wake the system. Pins are outputs when their direction bit is 0 and inputs when it is 1.

After reset, both the data latch and the direction register hold all ones. Every pin therefore starts as an input, and a pin later switched to output drives high unless its data bit was written first.

Pad levels pass through a synchronizer before they are read back or used for edge detection. While the low-power input is high, a high-to-low transition on any pin whose wake bit is set raises a wake-up request. The request stays high until low power ends.

The pin count is a parameter. On a narrower instance, the unused upper bits of the bus ignore writes and read as zero.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset the data latch and direction register hold all ones, `pad_oe` is 0, `pad_out` is all ones, the pull-up and wake select registers are 0, `pull_en` is 0 and `wake_req` is 0.
- R2: Pin i is an output (`pad_oe[i]`=1) when direction bit i is 0, and an input when it is 1.
- R3: A pin switched to output without a prior write to its data bit drives 1.
- R4: Register addresses are 0 for data, 1 for direction, 2 for pull-up select and 3 for wake select. A write with `reg_wr`=1 takes effect at the next clock edge. `reg_rdata` follows `reg_addr` in the same cycle with no added latency.
- R5: Reading address 0 returns the synchronized pad level for input pins and the data latch for output pins. A pad change becomes visible after two clock edges.
- R6: A single bit is set or cleared by a read-modify-write. The full byte read from address 0 is changed in one bit and written back whole. The written byte replaces the entire latch, including the latch bits of input pins.
- R7: `pull_en[i]` is 1 only when pull-up select bit i is 1 and pin i is an input.
- R8: While `low_power` is 1, a synchronized 1-to-0 transition on a pin whose wake select bit is 1 raises `wake_req` three clock edges after the pad falls. Falls on unselected pins do not raise it. The wake select value in force at the detecting edge is the one that applies.
- R9: Once raised, `wake_req` stays 1 while `low_power` stays 1. It clears at the first clock edge at which `low_power` is 0.
- R10: A falling edge that occurs while `low_power` is 0 never raises `wake_req`, including after `low_power` is later raised.
- R11: On an instance with WIDTH=4, bits 7 to 4 of every register read back as 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for the selected register |
| low_power | input | 1 | High while the system sleeps or idles |
| pad_in | input | WIDTH | Pad levels from the pins |
| pad_out | output | WIDTH | Level driven on output pins |
| pad_oe | output | WIDTH | Per-pin output enable |
| pull_en | output | WIDTH | Per-pin weak pull-up enable |
| wake_req | output | 1 | System wake-up request |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a bus write to the wake select register and the edge at which a synchronized fall reaches the detector. The bench times that write to land exactly on the detecting edge. It then expects no wake, because the select value in force before the edge governs.

The second pair is the release of low power and a detected fall. Here the clear must win. The behavioural reference model, compared on every clock, judges both orderings as they occur during the directed sequences.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
   localparam int ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      REG_DATA = 2'd0,
      REG_DIR  = 2'd1,
      REG_PULL = 2'd2,
      REG_WSEL = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= async_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_wake_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int BUS_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [WIDTH-1:0]  pin_sync,
   output logic [WIDTH-1:0]  data_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  pull_q,
   output logic [WIDTH-1:0]  wsel_q,
   output logic [BUS_W-1:0]  rdata
);
   localparam logic [WIDTH-1:0] ONES = '1;

   logic [WIDTH-1:0] wval;
   logic [WIDTH-1:0] rsel;
   reg_sel_e         sel;

   assign sel  = reg_sel_e'(addr);
   assign wval = wdata[WIDTH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= ONES;
         dir_q  <= ONES;
         pull_q <= '0;
         wsel_q <= '0;
      end else if (wr) begin
         case (sel)
            REG_DATA: data_q <= wval;
            REG_DIR:  dir_q  <= wval;
            REG_PULL: pull_q <= wval;
            REG_WSEL: wsel_q <= wval;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         REG_DATA: rsel = (dir_q & pin_sync) | (~dir_q & data_q);
         REG_DIR:  rsel = dir_q;
         REG_PULL: rsel = pull_q;
         REG_WSEL: rsel = wsel_q;
         default:  rsel = '0;
      endcase
   end

   if (WIDTH < BUS_W) begin : g_narrow
      assign rdata = {{(BUS_W-WIDTH){1'b0}}, rsel};
   end else begin : g_full
      assign rdata = rsel;
   end

   // R4
   data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == REG_DATA) |=> data_q == $past(wdata[WIDTH-1:0]));
   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == REG_DIR) |=> dir_q == $past(wdata[WIDTH-1:0]));
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_sync,
   input  logic [WIDTH-1:0] wsel,
   input  logic             low_power,
   output logic             wake_req
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_sync;
   end

   assign fall = prev_q & ~pin_sync & wsel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wake_req <= 1'b0;
      else if (!low_power) wake_req <= 1'b0;
      else if (|fall)      wake_req <= 1'b1;
   end

   // R10
   wake_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !low_power |=> !wake_req);
   // R9
   wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && low_power) |=> wake_req);
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
   import gpio_wake_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int BUS_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   input  logic              low_power,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pull_en,
   output logic              wake_req
);
   if (WIDTH < 1 || WIDTH > BUS_W) begin : g_bad_width
      $error("gpio_wake_port: WIDTH must lie in 1..BUS_W");
   end

   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] data_q, dir_q, pull_q, wsel_q;

   gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync));

   gpio_regs #(.WIDTH(WIDTH), .BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
      .wdata(reg_wdata), .pin_sync(pin_sync), .data_q(data_q),
      .dir_q(dir_q), .pull_q(pull_q), .wsel_q(wsel_q), .rdata(reg_rdata));

   gpio_wake #(.WIDTH(WIDTH)) u_wake (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .wsel(wsel_q),
      .low_power(low_power), .wake_req(wake_req));

   assign pad_out = data_q;
   assign pad_oe  = ~dir_q;
   assign pull_en = pull_q & dir_q;

   // R7
   pull_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_PULL) |=>
         (pull_en & ~$past(reg_wdata[WIDTH-1:0])) == '0);
endmodule

// File: tb/test_gpio_wake_port.sv
module test_gpio_wake_port;
   logic       clk = 0;
   logic       rst_n = 0;
   logic [1:0] reg_addr = 0;
   logic       reg_wr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata, n_rdata;
   logic       low_power = 0;
   logic [7:0] pad = 0;
   logic [7:0] pad_out, pad_oe, pull_en;
   logic [3:0] n_out, n_oe, n_pull;
   logic       wake_req, n_wake;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   gpio_wake_port i_gpio_wake_port (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .low_power(low_power),
      .pad_in(pad), .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
      .wake_req(wake_req));

   gpio_wake_port #(.WIDTH(4)) i_gpio_wake_port_narrow (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(n_rdata), .low_power(low_power),
      .pad_in(pad[3:0]), .pad_out(n_out), .pad_oe(n_oe), .pull_en(n_pull),
      .wake_req(n_wake));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic [7:0] m_data, m_dir, m_pull, m_wsel;
   logic       m_wake;
   logic [7:0] hist[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_data = 8'hFF; m_dir = 8'hFF; m_pull = 0; m_wsel = 0; m_wake = 0;
         hist = '{8'h00, 8'h00, 8'h00};
      end else begin
         logic [7:0] f;
         f = hist[2] & ~hist[1] & m_wsel;
         if (!low_power) m_wake = 0;
         else if (f != 0) m_wake = 1;
         if (reg_wr) begin
            case (reg_addr)
               2'd0: m_data = reg_wdata;
               2'd1: m_dir  = reg_wdata;
               2'd2: m_pull = reg_wdata;
               default: m_wsel = reg_wdata;
            endcase
         end
         hist.push_front(pad);
         void'(hist.pop_back());
      end
   end

   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         logic [7:0] er;
         case (reg_addr)
            2'd0: er = (m_dir & hist[1]) | (~m_dir & m_data);
            2'd1: er = m_dir;
            2'd2: er = m_pull;
            default: er = m_wsel;
         endcase
         check("R2 model pad_oe", pad_oe, ~m_dir);
         check("R3 model pad_out", pad_out, m_data);
         check("R7 model pull_en", pull_en, m_pull & m_dir);
         check("R8 model wake_req", {7'd0, wake_req}, {7'd0, m_wake});
         check("R5 model rdata", reg_rdata, er);
      end
   end

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic [7:0] dn);
      @(negedge clk);
      reg_addr = a;
      #2;
      d = reg_rdata;
      dn = n_rdata;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] rd, rn;
      cycles(3);
      rst_n = 1;
      cycles(1);
      // R1 reset state
      check("R1 pad_oe", pad_oe, 8'h00);
      check("R1 pad_out", pad_out, 8'hFF);
      check("R1 pull_en", pull_en, 8'h00);
      check("R1 wake_req", {7'd0, wake_req}, 8'h00);
      bus_read(2'd1, rd, rn);
      check("R1 dir read", rd, 8'hFF);
      bus_read(2'd3, rd, rn);
      check("R1 wsel read", rd, 8'h00);
      // R2 R3 low nibble becomes output, data untouched
      bus_write(2'd1, 8'hF0);
      check("R2 pad_oe", pad_oe, 8'h0F);
      check("R3 pad_out high", pad_out & 8'h0F, 8'h0F);
      // R5 mixed readback
      pad = 8'hA5;
      cycles(3);
      bus_read(2'd0, rd, rn);
      check("R5 mixed read", rd, 8'hAF);
      // R6 clear bit 1 by read-modify-write
      bus_write(2'd0, rd & ~8'h02);
      check("R6 latch", pad_out, 8'hAD);
      check("R6 oe kept", pad_oe, 8'h0F);
      bus_read(2'd0, rd, rn);
      check("R6 read back", rd, 8'hAD);
      // R7 pull only on inputs
      bus_write(2'd2, 8'hFF);
      check("R7 pull_en", pull_en, 8'hF0);
      // R8 wake on selected pin only
      bus_write(2'd1, 8'hFF);
      bus_write(2'd3, 8'h01);
      pad = 8'hFF;
      cycles(4);
      low_power = 1;
      cycles(1);
      pad = 8'hFB;
      cycles(5);
      check("R8 unselected ignored", {7'd0, wake_req}, 8'h00);
      pad = 8'hFA;
      cycles(2);
      check("R8 not yet", {7'd0, wake_req}, 8'h00);
      cycles(1);
      check("R8 wake raised", {7'd0, wake_req}, 8'h01);
      // R9 holds then clears
      pad = 8'hFF;
      cycles(6);
      check("R9 held", {7'd0, wake_req}, 8'h01);
      low_power = 0;
      cycles(1);
      check("R9 cleared", {7'd0, wake_req}, 8'h00);
      // R10 edge outside low power
      pad = 8'hFE;
      cycles(5);
      low_power = 1;
      cycles(5);
      check("R10 ignored", {7'd0, wake_req}, 8'h00);
      // R8 select written on the detecting edge: old select governs
      bus_write(2'd3, 8'h00);
      pad = 8'hFF;
      cycles(4);
      pad = 8'hFE;
      cycles(1);
      bus_write(2'd3, 8'h01);
      cycles(3);
      check("R8 concurrent select", {7'd0, wake_req}, 8'h00);
      low_power = 0;
      // R11 narrow instance
      bus_write(2'd1, 8'h00);
      bus_write(2'd0, 8'hFF);
      bus_write(2'd2, 8'hFF);
      bus_write(2'd3, 8'hFF);
      bus_read(2'd0, rd, rn);
      check("R11 data", rn, 8'h0F);
      bus_read(2'd1, rd, rn);
      check("R11 dir", rn, 8'h00);
      bus_write(2'd1, 8'hFF);
      bus_read(2'd1, rd, rn);
      check("R11 dir ones", rn, 8'h0F);
      bus_read(2'd2, rd, rn);
      check("R11 pull", rn, 8'h0F);
      bus_read(2'd3, rd, rn);
      check("R11 wsel", rn, 8'h0F);
      // R4 write lands on next edge, read is immediate
      @(negedge clk);
      reg_addr = 2'd2; reg_wdata = 8'h3C; reg_wr = 1;
      #2;
      check("R4 before edge", reg_rdata, 8'hFF);
      @(negedge clk);
      reg_wr = 0;
      #2;
      check("R4 after edge", reg_rdata, 8'h3C);
      cycles(2);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule